// File: doc/BRIEF.md
# Setup-Frame Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming frame is kept. It holds a small table of unicast station addresses. Software loads the table by streaming a 192-byte setup frame into the block, one byte per cycle. The frame is sixteen 12-byte entries. Each entry yields one 48-bit address, taken from a fixed, sparse set of byte offsets. Entries that carry a multicast address are dropped. The unicast ones are packed to the front of the table, and a count records how many there are.

The receive path presents each frame's destination address with a valid strobe. One cycle later the block answers accept or reject. A frame is accepted in three cases: promiscuous mode is on, the destination is multicast, or the destination equals a stored address. The table is double-buffered. A setup frame being loaded does not disturb the filter until its last byte arrives, so lookups made during a load still see the previous table.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, table_count_o is 0 and accept_valid_o is 0. With promiscuous mode off, a unicast destination is rejected.
- R2: accept_valid_o is high in exactly the cycle after a cycle in which chk_valid_i was high.
- R3: When promisc_i is high during a lookup, the frame is accepted whatever its destination.
- R4: A destination whose first byte has bit 0 set is accepted. The first byte is chk_da_i[47:40], so this is bit 40.
- R5: With promisc_i low, a unicast destination is accepted only if it equals one of the first table_count_o stored addresses.
- R6: Within each 12-byte entry, address bytes 0..5 come from entry offsets 0, 1, 4, 5, 8 and 9. Address byte 0 is the most significant byte. Bytes at offsets 2, 3, 6, 7, 10 and 11 have no effect on the address.
- R7: An entry whose address byte 0 has bit 0 set is not stored. Unicast entries are stored in arrival order. After the frame, table_count_o equals the number of unicast entries, from 0 to 16.
- R8: table_count_o and the lookup table change only on the cycle that takes the 192nd setup byte. Lookups made before that use the previous table.
- R9: setup_start_i marks the byte in the same cycle as byte 0 of a new setup frame. It discards any partly received frame and restarts the stored-address count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| promisc_i | input | 1 | Promiscuous mode, accept every frame |
| setup_start_i | input | 1 | Current setup byte is the first of a new frame |
| setup_valid_i | input | 1 | Setup byte strobe |
| setup_byte_i | input | 8 | Setup frame byte |
| chk_valid_i | input | 1 | Destination address lookup request |
| chk_da_i | input | 48 | Destination address, first byte in bits 47:40 |
| accept_valid_o | output | 1 | Lookup result valid |
| accept_o | output | 1 | Frame accepted |
| table_count_o | output | $clog2(N_ENTRIES+1) | Number of stored unicast addresses |

## Verification
The bench builds the block with the default N_ENTRIES of 16. At that size the full 192-byte frame format applies, and the count can reach its top value of 16 when every entry is unicast. It can also reach zero when every entry is multicast. Random frames mix unicast and multicast entries, and the bench checks that the packing and count come out right. Lookups draw from stored addresses, near-miss unicast addresses, multicast addresses and promiscuous mode. Directed cases cover a lookup during a partial load, a restart in the middle of a frame, and an address built from the skipped offsets.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int N_ENTRIES = 16,
  localparam int ENTRY_BYTES = 12,
  localparam int CW = $clog2(N_ENTRIES + 1),
  localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          promisc_i,
  input  logic          setup_start_i,
  input  logic          setup_valid_i,
  input  logic [7:0]    setup_byte_i,
  input  logic          chk_valid_i,
  input  logic [47:0]   chk_da_i,
  output logic          accept_valid_o,
  output logic          accept_o,
  output logic [CW-1:0] table_count_o
);

  logic [3:0]    byte_pos;
  logic [EW-1:0] entry_pos;
  logic [CW-1:0] sh_cnt, act_cnt;
  logic [47:0]   asm_q, asm_next;
  logic [47:0]   sh_tab  [N_ENTRIES];
  logic [47:0]   act_tab [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit;

  wire [3:0]    pos_eff   = setup_start_i ? 4'd0 : byte_pos;
  wire [EW-1:0] entry_eff = setup_start_i ? '0 : entry_pos;
  wire [CW-1:0] cnt_eff   = setup_start_i ? '0 : sh_cnt;
  wire          is_addr   = setup_valid_i && !pos_eff[1];
  wire [2:0]    slot      = {pos_eff[3:2], pos_eff[0]};
  wire          entry_end = setup_valid_i && (pos_eff == 4'(ENTRY_BYTES - 1));
  wire          frame_end = entry_end && (entry_eff == EW'(N_ENTRIES - 1));
  wire          store     = entry_end && !asm_q[40];
  wire [CW-1:0] cnt_next  = cnt_eff + CW'(store);

  always_comb begin
    asm_next = asm_q;
    for (int k = 0; k < 6; k++)
      if (is_addr && slot == 3'(k)) asm_next[47 - 8*k -: 8] = setup_byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_pos  <= '0;
      entry_pos <= '0;
      sh_cnt    <= '0;
      act_cnt   <= '0;
      asm_q     <= '0;
    end else begin
      if (setup_valid_i) begin
        byte_pos  <= entry_end ? 4'd0 : pos_eff + 4'd1;
        entry_pos <= frame_end ? '0 : (entry_end ? entry_eff + EW'(1) : entry_eff);
        sh_cnt    <= frame_end ? '0 : cnt_next;
        asm_q     <= asm_next;
        if (frame_end) act_cnt <= cnt_next;
      end else if (setup_start_i) begin
        byte_pos  <= '0;
        entry_pos <= '0;
        sh_cnt    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) sh_tab[cnt_eff[EW-1:0]] <= asm_q;
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (frame_end)
        act_tab[i] <= (store && cnt_eff == CW'(i)) ? asm_q : sh_tab[i];
    end
    assign hit[i] = (CW'(i) < act_cnt) && (act_tab[i] == chk_da_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_valid_o <= 1'b0;
      accept_o       <= 1'b0;
    end else begin
      accept_valid_o <= chk_valid_i;
      accept_o       <= chk_valid_i && (promisc_i || chk_da_i[40] || |hit);
    end
  end

  assign table_count_o = act_cnt;

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    table_count_o <= CW'(N_ENTRIES));
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> accept_valid_o);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !accept_valid_o && !accept_o);
  p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && promisc_i) |=> accept_o);
  p_mcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && chk_da_i[40]) |=> accept_o);
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_valid_i |=> $stable(table_count_o));

endmodule

// File: tb/dest_addr_filter_tb_top.sv
`timescale 1ns/1ps
module dest_addr_filter_tb_top;
  localparam int N = 16;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic promisc_i = 1'b0, setup_start_i = 1'b0, setup_valid_i = 1'b0, chk_valid_i = 1'b0;
  logic [7:0] setup_byte_i = '0;
  logic [47:0] chk_da_i = '0;
  logic accept_valid_o, accept_o;
  logic [CW-1:0] table_count_o;

  always #2.5 clk = ~clk;

  dest_addr_filter #(.N_ENTRIES(N)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [47:0] frame_addr [N];
  logic [47:0] ref_tab [N];
  int ref_cnt = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expect_accept(input logic [47:0] da, input logic pm);
    logic r = pm || da[40];
    for (int i = 0; i < ref_cnt; i++) if (ref_tab[i] == da) r = 1'b1;
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic first);
    @(negedge clk);
    setup_valid_i = 1'b1; setup_start_i = first; setup_byte_i = b;
    @(negedge clk);
    setup_valid_i = 1'b0; setup_start_i = 1'b0;
  endtask

  // sends the first nbytes of a frame built from frame_addr; filler of entry 0 is fixed
  task automatic load_frame(input int nbytes);
    for (int p = 0; p < nbytes; p++) begin
      int e = p / 12, off = p % 12;
      logic [7:0] b;
      if (off % 4 < 2) b = frame_addr[e][47 - 8*((off/4)*2 + off%2) -: 8];
      else if (e == 0) b = 8'h20 + 8'(off);
      else b = 8'($urandom);
      send_byte(b, p == 0);
    end
    if (nbytes == 12*N) begin
      ref_cnt = 0;
      for (int e = 0; e < N; e++)
        if (!frame_addr[e][40]) begin ref_tab[ref_cnt] = frame_addr[e]; ref_cnt++; end
    end
  endtask

  task automatic lookup(input string req, input logic [47:0] da, input logic pm);
    @(negedge clk);
    chk_valid_i = 1'b1; chk_da_i = da; promisc_i = pm;
    @(posedge clk); #1;
    chk({req, " valid"}, 64'(accept_valid_o), 64'd1);
    chk(req, 64'(accept_o), 64'(expect_accept(da, pm)));
    @(negedge clk);
    chk_valid_i = 1'b0; promisc_i = 1'b0;
  endtask

  function automatic logic [47:0] rnd_addr(input logic mc);
    logic [47:0] a = {$urandom, $urandom}[47:0];
    a[40] = mc;
    return a;
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", 64'(table_count_o), 64'd0);
    chk("R1 valid", 64'(accept_valid_o), 64'd0);
    lookup("R1 empty reject", 48'h02_11_22_33_44_55, 1'b0);

    // directed frame: entries 3 and 7 multicast
    for (int e = 0; e < N; e++) frame_addr[e] = {8'h02, 8'(e), 32'hA0B0C0D0};
    frame_addr[3][40] = 1'b1;
    frame_addr[7][40] = 1'b1;
    load_frame(12*N);
    chk("R7 count 14", 64'(table_count_o), 64'd14);
    for (int e = 0; e < N; e++) lookup("R5 R6 stored", frame_addr[e], 1'b0);
    lookup("R6 skipped offsets", {8'h22, 8'h23, 8'h26, 8'h27, 8'h2A, 8'h2B}, 1'b0);
    lookup("R5 near miss", frame_addr[0] ^ 48'h1, 1'b0);
    @(posedge clk); #1;
    chk("R2 idle", 64'(accept_valid_o), 64'd0);
    lookup("R3 promisc", 48'h02_DE_AD_BE_EF_00, 1'b1);
    lookup("R4 mcast", 48'h01_00_5E_00_00_01, 1'b0);
    lookup("R4 broadcast", 48'hFF_FF_FF_FF_FF_FF, 1'b0);

    // partial load leaves old table in force
    for (int e = 0; e < N; e++) frame_addr[e] = {8'h04, 8'(e), 32'h11223344};
    load_frame(100);
    chk("R8 count held", 64'(table_count_o), 64'd14);
    lookup("R8 old entry", {8'h02, 8'd5, 32'hA0B0C0D0}, 1'b0);
    lookup("R8 new not yet", frame_addr[0], 1'b0);
    chk("R8 new rejected", 64'(accept_o), 64'd0);

    // restart mid-frame, all unicast fills the table
    load_frame(12*N);
    chk("R9 R7 full count", 64'(table_count_o), 64'd16);
    lookup("R9 new entry", frame_addr[15], 1'b0);
    lookup("R9 old gone", {8'h02, 8'd5, 32'hA0B0C0D0}, 1'b0);
    chk("R9 old rejected", 64'(accept_o), 64'd0);

    // all multicast empties the table
    for (int e = 0; e < N; e++) frame_addr[e] = rnd_addr(1'b1);
    load_frame(12*N);
    chk("R7 zero count", 64'(table_count_o), 64'd0);
    lookup("R5 empty unicast", 48'h04_00_11_22_33_44, 1'b0);

    for (int f = 0; f < 12; f++) begin
      for (int e = 0; e < N; e++) frame_addr[e] = rnd_addr(($urandom % 4) == 0);
      load_frame(12*N);
      chk("R7 random count", 64'(table_count_o), 64'(ref_cnt));
      for (int k = 0; k < 25; k++) begin
        int sel = $urandom % 4;
        logic [47:0] da;
        if (sel == 0) da = frame_addr[$urandom % N];
        else if (sel == 1) da = frame_addr[$urandom % N] ^ (48'h1 << (1 + $urandom % 40));
        else da = rnd_addr(sel == 2 ? 1'b0 : 1'($urandom));
        lookup("R3 R4 R5 random", da, ($urandom % 6) == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule